// File: doc/BRIEF.md
# Chained Serial Angle Readout Slave

This block is the slave end of a synchronous serial link that reads out an absolute angle sample. A master drives a slow serial clock into `ma`, and the block answers on `slo`. The first rising edge of `ma` on an idle link captures the current angle word and a fault flag. Later rising edges then shift out a frame on `slo`. The frame has a low acknowledge, an optional low hold-off, a high start bit, the angle bits most significant first, an active-low error bit and a 4-bit check code. The check code is seeded from a per-device ID, so a mis-assigned or swapped slave fails the master's check.

Once its own frame has been sent, the block copies whatever arrives on `sli` to `slo`, one bit per `ma` rising edge. Slaves can therefore be strung together, each `slo` feeding the previous one's `sli`, and read as one long word. When `ma` stops changing for a set number of system clock cycles, the frame ends. `slo` goes high again and the next rising edge captures a fresh sample.

`ma` is resynchronised into the `clk` domain. `sli`, `angle`, `fault` and `crc_seed` are sampled directly and must be stable around the `ma` rising edges.

Top module: `angle_chain_tx`

## Requirements
- R1: After reset `slo` is high and the block is idle, ready to capture.
- R2: A rising edge of `ma` while idle captures `angle`, `fault` and `crc_seed`, and drives `slo` low as the acknowledge.
- R3: The next HOLD_CYC rising edges of `ma` keep `slo` low. The rising edge after those drives the start bit, which is high.
- R4: The next ANGLE_W rising edges place the captured angle on `slo`, most significant bit first, one bit per edge.
- R5: The next rising edge places the error bit, which is the inverse of the captured `fault` (low means a fault).
- R6: The next four rising edges place the check code c3 down to c0. The code starts from `crc_seed` and takes in the angle bits MSB first and then the error bit. For each input bit b: f = c3 xor b; c = {c2,c1,c0,0}; if f is 1, c = c xor 4'b0011. This is the generator x^4+x+1.
- R7: Every later rising edge of `ma` drives `slo` with the value of `sli` sampled at that edge.
- R8: If `ma` shows no transition for TMO_CYC consecutive clock cycles during a frame, `slo` returns high and the block goes idle. The next rising edge captures a new sample.
- R9: Rising edges that arrive before the timeout never re-capture. A pause shorter than TMO_CYC resumes the frame at the next bit, and after the code bits the edges keep forwarding `sli`.
- R10: `slo` changes only at the clock edge that comes SYNC_STAGES edges after the edge at which an `ma` rise is first sampled, or when the timeout fires. It holds its value at every other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ma | input | 1 | Serial clock from the master, asynchronous |
| sli | input | 1 | Serial data from the next slave in the chain |
| angle | input | ANGLE_W | Current absolute angle sample |
| fault | input | 1 | Current fault flag, active high |
| crc_seed | input | CRC_W | Per-device seed for the check code |
| slo | output | 1 | Serial data to the master or the previous slave |

## Verification
An `ma` rise first sampled at clock edge n reaches `slo` at edge n+2 with the default two synchroniser stages. A timeout takes effect at the edge that ends the TMO_CYC-th quiet cycle. The bench's reference model keeps the last three sampled `ma` values and acts on the copy from two edges back, so its expected `slo` is due in the same clock as the design's. `slo` is compared against it at every falling clock edge, half a period away from the register update. Pulses are wide and `sli` is only changed while `ma` is low, so the sampled `sli` is the same for both.

// File: rtl/acx_pkg.sv
package acx_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HOLD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_FWD   = 2'd3
   } tx_state_e;
endpackage

// File: rtl/ac_sync.sv
module ac_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] flops;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flops <= '0;
            else if (STAGES == 1) flops <= d;
            else flops <= {flops[STAGES-2:0], d};
         end
         assign q = flops[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/ac_timeout.sv
module ac_timeout #(
   parameter int TMO_CYC = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic activity,
   input  logic armed,
   output logic fire
);
   localparam int CNT_W = $clog2(TMO_CYC);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TMO_CYC - 1);

   logic [CNT_W-1:0] quiet_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) quiet_cnt <= '0;
      else if (activity) quiet_cnt <= '0;
      else if (quiet_cnt != LIMIT) quiet_cnt <= quiet_cnt + 1'b1;
   end

   assign fire = armed && !activity && (quiet_cnt == LIMIT);
endmodule

// File: rtl/ac_crc.sv
module ac_crc #(
   parameter int          DATA_W = 9,
   parameter int          CRC_W  = 4,
   parameter logic [CRC_W-1:0] POLY = 4'h3
) (
   input  logic [CRC_W-1:0]  seed,
   input  logic [DATA_W-1:0] data,
   output logic [CRC_W-1:0]  crc
);
   logic [CRC_W-1:0] stage [DATA_W+1];

   assign stage[0] = seed;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_bit
         logic fb;
         assign fb = stage[i][CRC_W-1] ^ data[DATA_W-1-i];
         assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
      end
   endgenerate

   assign crc = stage[DATA_W];
endmodule

// File: rtl/ac_framer.sv
module ac_framer
   import acx_pkg::*;
#(
   parameter int ANGLE_W  = 8,
   parameter int CRC_W    = 4,
   parameter int HOLD_CYC = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ma_rise,
   input  logic               tmo_fire,
   input  logic               sli,
   input  logic [ANGLE_W-1:0] angle,
   input  logic               fault,
   input  logic [CRC_W-1:0]   crc_val,
   output logic               slo,
   output logic               st_idle,
   output logic               st_fwd
);
   localparam int FRAME_W = 1 + ANGLE_W + 1 + CRC_W;
   localparam int BIT_W   = $clog2(FRAME_W);
   localparam int HOLD_W  = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

   tx_state_e          st;
   logic [FRAME_W-1:0] shreg;
   logic [BIT_W-1:0]   bits_left;
   logic [HOLD_W-1:0]  hold_left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         slo       <= 1'b1;
         shreg     <= '0;
         bits_left <= '0;
         hold_left <= '0;
      end else if (tmo_fire) begin
         st  <= ST_IDLE;
         slo <= 1'b1;
      end else if (ma_rise) begin
         unique case (st)
            ST_IDLE: begin
               shreg     <= {1'b1, angle, ~fault, crc_val};
               slo       <= 1'b0;
               hold_left <= HOLD_W'(HOLD_CYC);
               st        <= ST_HOLD;
            end
            ST_HOLD: begin
               if (hold_left == '0) begin
                  slo       <= shreg[FRAME_W-1];
                  shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                  bits_left <= BIT_W'(FRAME_W - 1);
                  st        <= ST_SHIFT;
               end else begin
                  hold_left <= hold_left - 1'b1;
                  slo       <= 1'b0;
               end
            end
            ST_SHIFT: begin
               if (bits_left == '0) begin
                  slo <= sli;
                  st  <= ST_FWD;
               end else begin
                  slo       <= shreg[FRAME_W-1];
                  shreg     <= {shreg[FRAME_W-2:0], 1'b0};
                  bits_left <= bits_left - 1'b1;
               end
            end
            ST_FWD: slo <= sli;
         endcase
      end
   end

   assign st_idle = (st == ST_IDLE);
   assign st_fwd  = (st == ST_FWD);
endmodule

// File: rtl/angle_chain_tx.sv
module angle_chain_tx #(
   parameter int               ANGLE_W     = 8,
   parameter int               CRC_W       = 4,
   parameter logic [CRC_W-1:0] CRC_POLY    = 4'h3,
   parameter int               SYNC_STAGES = 2,
   parameter int               HOLD_CYC    = 0,
   parameter int               TMO_CYC     = 2500
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ma,
   input  logic               sli,
   input  logic [ANGLE_W-1:0] angle,
   input  logic               fault,
   input  logic [CRC_W-1:0]   crc_seed,
   output logic               slo
);
   localparam int PROT_W = ANGLE_W + 1;

   generate
      if (ANGLE_W < 1) begin : g_bad_angle
         $error("ANGLE_W must be at least 1");
      end
      if (CRC_W < 2) begin : g_bad_crc
         $error("CRC_W must be at least 2");
      end
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("TMO_CYC must be at least 2");
      end
      if (HOLD_CYC < 0 || SYNC_STAGES < 0) begin : g_bad_cnt
         $error("HOLD_CYC and SYNC_STAGES must not be negative");
      end
   endgenerate

   logic ma_s, ma_q, ma_rise, ma_chg;
   logic tmo_fire, st_idle, st_fwd;
   logic [CRC_W-1:0] crc_val;

   ac_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ma), .q(ma_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ma_q <= 1'b0;
      else ma_q <= ma_s;
   end

   assign ma_rise = ma_s & ~ma_q;
   assign ma_chg  = ma_s ^ ma_q;

   ac_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
      .clk(clk), .rst_n(rst_n), .activity(ma_chg), .armed(~st_idle), .fire(tmo_fire)
   );

   ac_crc #(.DATA_W(PROT_W), .CRC_W(CRC_W), .POLY(CRC_POLY)) u_crc (
      .seed(crc_seed), .data({angle, ~fault}), .crc(crc_val)
   );

   ac_framer #(.ANGLE_W(ANGLE_W), .CRC_W(CRC_W), .HOLD_CYC(HOLD_CYC)) u_framer (
      .clk(clk), .rst_n(rst_n), .ma_rise(ma_rise), .tmo_fire(tmo_fire),
      .sli(sli), .angle(angle), .fault(fault), .crc_val(crc_val),
      .slo(slo), .st_idle(st_idle), .st_fwd(st_fwd)
   );
endmodule

// File: rtl/angle_chain_tx_chk.sv
module angle_chain_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic slo,
   input logic sli,
   input logic ma_rise,
   input logic tmo_fire,
   input logic st_idle,
   input logic st_fwd
);
   a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      st_idle |-> slo);

   a_r2_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
      (st_idle && ma_rise) |=> (!slo && !st_idle));

   a_r7_forward: assert property (@(posedge clk) disable iff (!rst_n)
      (st_fwd && ma_rise && !tmo_fire) |=> (slo == $past(sli)));

   a_r8_timeout_idle: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_fire |=> (slo && st_idle));

   a_r9_no_relatch: assert property (@(posedge clk) disable iff (!rst_n)
      (!st_idle && ma_rise && !tmo_fire) |=> !st_idle);

   a_r10_hold_level: assert property (@(posedge clk) disable iff (!rst_n)
      (!ma_rise && !tmo_fire) |=> $stable(slo));
endmodule

bind angle_chain_tx angle_chain_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .slo(slo), .sli(sli), .ma_rise(ma_rise),
   .tmo_fire(tmo_fire), .st_idle(st_idle), .st_fwd(st_fwd)
);

// File: tb/test_angle_chain_tx.sv
module test_angle_chain_tx;
   localparam int HALF = 4;
   localparam int HOLD = 2;
   localparam int TMO  = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ma = 1'b0;
   logic       sli = 1'b0;
   logic       fault = 1'b0;
   logic [7:0] angle = 8'h00;
   logic [3:0] seed = 4'h0;
   logic       slo;

   always #2 clk = ~clk;

   angle_chain_tx #(
      .ANGLE_W(8), .CRC_W(4), .CRC_POLY(4'h3),
      .SYNC_STAGES(2), .HOLD_CYC(HOLD), .TMO_CYC(TMO)
   ) i_angle_chain_tx (
      .clk(clk), .rst_n(rst_n), .ma(ma), .sli(sli), .angle(angle),
      .fault(fault), .crc_seed(seed), .slo(slo)
   );

   int    total = 0;
   int    bad = 0;
   int    cyc = 0;
   string phase = "R1 reset";

   // reference model state
   logic  p1, p2, p3, ma_a, ma_b;
   int    quiet;
   bit    busy;
   logic  exp_slo = 1'b1;
   string exp_tag = "R1";
   logic  q_bits[$];
   string q_tags[$];

   function automatic logic [3:0] ref_crc(input logic [3:0] s, input logic [8:0] d);
      for (int i = 8; i >= 0; i--) begin
         logic f;
         f = s[3] ^ d[i];
         s = {s[2:0], 1'b0};
         if (f) s = s ^ 4'h3;
      end
      return s;
   endfunction

   task automatic load_frame();
      logic [3:0] c;
      c = ref_crc(seed, {angle, ~fault});
      q_bits.push_back(1'b0); q_tags.push_back("R2");
      for (int i = 0; i < HOLD; i++) begin
         q_bits.push_back(1'b0); q_tags.push_back("R3");
      end
      q_bits.push_back(1'b1); q_tags.push_back("R3");
      for (int i = 7; i >= 0; i--) begin
         q_bits.push_back(angle[i]); q_tags.push_back("R4");
      end
      q_bits.push_back(~fault); q_tags.push_back("R5");
      for (int i = 3; i >= 0; i--) begin
         q_bits.push_back(c[i]); q_tags.push_back("R6");
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         p1 = 1'b0; p2 = 1'b0; p3 = 1'b0; quiet = 0; busy = 1'b0;
         exp_slo = 1'b1; exp_tag = "R1";
         q_bits.delete(); q_tags.delete();
      end else begin
         ma_a = p2;
         ma_b = p3;
         quiet = (ma_a != ma_b) ? 0 : quiet + 1;
         if (!busy) begin
            if (ma_a && !ma_b) begin
               load_frame();
               busy = 1'b1;
               exp_slo = q_bits.pop_front();
               exp_tag = q_tags.pop_front();
            end
         end else if (quiet == TMO) begin
            busy = 1'b0;
            exp_slo = 1'b1;
            exp_tag = "R8";
         end else if (ma_a && !ma_b) begin
            if (q_bits.size() > 0) begin
               exp_slo = q_bits.pop_front();
               exp_tag = q_tags.pop_front();
            end else begin
               exp_slo = sli;
               exp_tag = "R7";
            end
         end
         p3 = p2; p2 = p1; p1 = ma;
      end
   end

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   // R10: every clock the output must match the model, due in the same cycle
   always @(negedge clk) begin
      total++;
      if (slo !== exp_slo) begin
         bad++;
         $display("FAIL %s (%s) cycle %0d: slo=%b expected=%b", exp_tag, phase, cyc, slo, exp_slo);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000) begin
         bad++;
         $display("FAIL R10 watchdog: cycles=%0d expected below %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic pulse(input logic s);
      sli = s;
      ma = 1'b1;
      repeat (HALF) @(negedge clk);
      ma = 1'b0;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic idle_for(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic frame(input logic [7:0] a, input logic f, input logic [3:0] s,
                        input int nfwd, input logic [7:0] pat);
      angle = a; fault = f; seed = s;
      for (int i = 0; i < 1 + HOLD + 1 + 13; i++) pulse(1'b0);
      for (int i = 0; i < nfwd; i++) pulse(pat[i]);
      idle_for(TMO + 10);
   endtask

   initial begin
      idle_for(5);
      rst_n = 1'b1;
      idle_for(6);

      phase = "R4 first frame";
      frame(8'hA5, 1'b0, 4'h0, 3, 8'b101);

      phase = "R5 fault set";
      frame(8'h3C, 1'b1, 4'h9, 2, 8'b10);

      phase = "R6 seed F";
      frame(8'h00, 1'b0, 4'hF, 1, 8'b1);
      phase = "R6 seed 6";
      frame(8'hFF, 1'b1, 4'h6, 1, 8'b0);
      phase = "R6 seed 3";
      frame(8'h80, 1'b0, 4'h3, 4, 8'b0110);

      phase = "R9 pause and relatch";
      angle = 8'h5A; fault = 1'b0; seed = 4'hC;
      for (int i = 0; i < 6; i++) pulse(1'b0);
      idle_for(TMO / 2);
      angle = 8'h11;
      for (int i = 6; i < 1 + HOLD + 1 + 13; i++) pulse(1'b0);
      pulse(1'b1);
      angle = 8'hE7; fault = 1'b1;
      idle_for(TMO / 2);
      pulse(1'b1);
      pulse(1'b0);
      pulse(1'b1);
      idle_for(TMO + 10);

      phase = "R8 fresh capture";
      frame(8'h11, 1'b0, 4'h5, 2, 8'b11);

      idle_for(10);
      finish_run();
   end
endmodule